// File: doc/BRIEF.md
# Timer Compare Match Output Unit

This block turns timer compare events into a level on a waveform pin. It keeps a one-bit compare state register that is separate from the pin. On a compare-match strobe or a force strobe, a two-bit action field decides what happens to that register. It can keep its value, invert, go low or go high. Software can also load the register directly, so the first level the pin will show is known before the pin is ever enabled.

The same action field picks the pin's data source. A non-zero field routes the compare state to the pin, and a zero field leaves the pin to the general-purpose port data bit. The pin direction is never taken over by the field: a separate direction bit alone sets the output enable. The counter, the comparator and any PWM mode decoding sit outside this block. All state changes happen on the rising clock edge, and reset is synchronous and active low.

Top module: `cmp_output_unit`

## Requirements
- R1: While `rst_n` is 0 at a rising edge, the compare state becomes 0. With `act_mode_i` non-zero and `dir_out_i` = 1, `pin_o` then reads 0.
- R2: A compare event with `act_mode_i` = 2'b01 inverts the compare state at that edge.
- R3: A compare event with `act_mode_i` = 2'b10 makes the compare state 0 at that edge.
- R4: A compare event with `act_mode_i` = 2'b11 makes the compare state 1 at that edge.
- R5: A compare event with `act_mode_i` = 2'b00 leaves the compare state unchanged.
- R6: `force_i` alone acts on the compare state exactly as `match_i` would under the same `act_mode_i`. Both strobes together count as one event.
- R7: With no compare event, `sw_wr_i` = 1 loads `sw_dat_i` into the compare state at that edge.
- R8: When a compare event and `sw_wr_i` fall in the same cycle, the event decides the new state and the software value is dropped. This also holds when `act_mode_i` = 2'b00.
- R9: With `dir_out_i` = 1, `pin_o` equals the compare state when either `act_mode_i` bit is 1, and equals `port_dat_i` when `act_mode_i` = 2'b00.
- R10: `pin_oe_o` always equals `dir_out_i`. With `dir_out_i` = 0, `pin_o` is driven as 0 regardless of mode, state or port data.
- R11: A state loaded while `dir_out_i` = 0 is kept. It appears on `pin_o` in the same cycle that `dir_out_i` becomes 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| match_i | input | 1 | Compare-match strobe from the timer |
| force_i | input | 1 | Software force strobe, treated as a match |
| act_mode_i | input | 2 | Action field: 00 hold, 01 invert, 10 clear, 11 set; non-zero selects compare state as pin source |
| port_dat_i | input | 1 | General-purpose port data bit |
| dir_out_i | input | 1 | Direction bit, 1 = output |
| sw_wr_i | input | 1 | Direct write strobe for the compare state |
| sw_dat_i | input | 1 | Value for the direct write |
| pin_o | output | 1 | Pin drive value |
| pin_oe_o | output | 1 | Pin output enable |

## Verification
The state path is swept over every combination of prior state, action field, match strobe, force strobe, write strobe and write value. This separates the four actions from each other, match from force, and event priority from write priority. The state is read back through the pin with the invert field selected and no strobe active. The pin path is swept over every action field, direction and port value with both state values loaded. This separates the override from the port fall-through and the direction gating from both. Two further sequences cover reset from a set state and a preset made while the pin is an input.

// File: rtl/cmpout_pkg.sv
// Package: cmpout_pkg
// Shared widths and the decoded action type for the compare output unit.
// Assumes a two-bit action field; the field encoding is fixed by behaviour.
package cmpout_pkg;
    localparam int MODE_W = 2;

    typedef logic [MODE_W-1:0] mode_t;

    localparam mode_t MODE_HOLD   = 2'b00;
    localparam mode_t MODE_INVERT = 2'b01;
    localparam mode_t MODE_CLEAR  = 2'b10;
    localparam mode_t MODE_SET    = 2'b11;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_INVERT = 2'd1,
        ACT_CLEAR  = 2'd2,
        ACT_SET    = 2'd3
    } act_e;
endpackage

// File: rtl/cmpout_action.sv
// Module: cmpout_action
// Merges the match and force strobes into one event and decodes the
// action field into an action code. Purely combinational.
// Assumes strobes are single-cycle and synchronous to the unit clock.
module cmpout_action
    import cmpout_pkg::*;
(
    input  mode_t mode_i,
    input  logic  match_i,
    input  logic  force_i,
    output logic  evt_o,
    output act_e  act_o
);

    // Purpose: a force is indistinguishable from a real match
    always_comb begin
        evt_o = match_i | force_i;
    end

    // Purpose: map the field value to the action applied on an event
    always_comb begin
        unique case (mode_i)
            MODE_INVERT: act_o = ACT_INVERT;
            MODE_CLEAR:  act_o = ACT_CLEAR;
            MODE_SET:    act_o = ACT_SET;
            default:     act_o = ACT_HOLD;
        endcase
    end

endmodule

// File: rtl/cmpout_state.sv
// Module: cmpout_state
// Holds the internal compare state bit. An event applies the decoded
// action; otherwise a software write loads a value. Events win over
// writes in the same cycle, including hold events.
// Assumes synchronous active-low reset to 0.
module cmpout_state
    import cmpout_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  act_e act_i,
    input  logic wr_i,
    input  logic wr_dat_i,
    output logic state_o
);

    logic state_nxt;

    // Purpose: choose the next state from event action or software write
    always_comb begin
        state_nxt = state_o;
        if (evt_i) begin
            unique case (act_i)
                ACT_INVERT: state_nxt = ~state_o;
                ACT_CLEAR:  state_nxt = 1'b0;
                ACT_SET:    state_nxt = 1'b1;
                default:    state_nxt = state_o;
            endcase
        end else if (wr_i) begin
            state_nxt = wr_dat_i;
        end
    end

    // Purpose: register the compare state with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_o <= 1'b0;
        end else begin
            state_o <= state_nxt;
        end
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> !state_o);

    // R2
    invert_flips_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && act_i == ACT_INVERT) |=> (state_o != $past(state_o)));

    // R3
    clear_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && act_i == ACT_CLEAR) |=> !state_o);

    // R4
    set_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && act_i == ACT_SET) |=> state_o);

    // R5 R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && act_i == ACT_HOLD) |=> $stable(state_o));

    // R7
    sw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_i && wr_i) |=> (state_o == $past(wr_dat_i)));

endmodule

// File: rtl/cmpout_pin_mux.sv
// Module: cmpout_pin_mux
// Selects the pin data source and gates it with the direction bit.
// Any non-zero action field overrides the port data; direction is
// never overridden. Combinational; assertions sample on the clock.
module cmpout_pin_mux
    import cmpout_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_t mode_i,
    input  logic  state_i,
    input  logic  port_dat_i,
    input  logic  dir_out_i,
    output logic  pin_o,
    output logic  pin_oe_o
);

    logic override;

    // Purpose: the compare state owns the pin data when any field bit is set
    always_comb begin
        override = |mode_i;
    end

    // Purpose: drive pin data and enable; an input pin is driven as 0
    always_comb begin
        pin_oe_o = dir_out_i;
        if (!dir_out_i) begin
            pin_o = 1'b0;
        end else if (override) begin
            pin_o = state_i;
        end else begin
            pin_o = port_dat_i;
        end
    end

    // R9
    override_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_out_i && mode_i != MODE_HOLD) |-> (pin_o == state_i));

    // R9
    port_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_out_i && mode_i == MODE_HOLD) |-> (pin_o == port_dat_i));

    // R10
    input_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_out_i |-> (!pin_o && !pin_oe_o));

endmodule

// File: rtl/cmp_output_unit.sv
// Module: cmp_output_unit
// Top of the compare match output unit: event/action decode, compare
// state register and pin source mux.
// Assumes all inputs are synchronous to clk.
module cmp_output_unit
    import cmpout_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        match_i,
    input  logic        force_i,
    input  logic [1:0]  act_mode_i,
    input  logic        port_dat_i,
    input  logic        dir_out_i,
    input  logic        sw_wr_i,
    input  logic        sw_dat_i,
    output logic        pin_o,
    output logic        pin_oe_o
);

    logic evt;
    act_e act;
    logic cmp_state;

    cmpout_action u_action (
        .mode_i  (act_mode_i),
        .match_i (match_i),
        .force_i (force_i),
        .evt_o   (evt),
        .act_o   (act)
    );

    cmpout_state u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt),
        .act_i    (act),
        .wr_i     (sw_wr_i),
        .wr_dat_i (sw_dat_i),
        .state_o  (cmp_state)
    );

    cmpout_pin_mux u_pin (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (act_mode_i),
        .state_i    (cmp_state),
        .port_dat_i (port_dat_i),
        .dir_out_i  (dir_out_i),
        .pin_o      (pin_o),
        .pin_oe_o   (pin_oe_o)
    );

    // R6
    force_is_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_i && act_mode_i == 2'b11) |=> (!dir_out_i || act_mode_i == 2'b00 || pin_o));

    // R10
    oe_follows_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe_o == dir_out_i);

endmodule

// File: tb/test_cmp_output_unit.sv
module test_cmp_output_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       match_i = 1'b0;
    logic       force_i = 1'b0;
    logic [1:0] act_mode_i = 2'b00;
    logic       port_dat_i = 1'b0;
    logic       dir_out_i = 1'b0;
    logic       sw_wr_i = 1'b0;
    logic       sw_dat_i = 1'b0;
    logic       pin_o;
    logic       pin_oe_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cmp_output_unit i_cmp_output_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .match_i    (match_i),
        .force_i    (force_i),
        .act_mode_i (act_mode_i),
        .port_dat_i (port_dat_i),
        .dir_out_i  (dir_out_i),
        .sw_wr_i    (sw_wr_i),
        .sw_dat_i   (sw_dat_i),
        .pin_o      (pin_o),
        .pin_oe_o   (pin_oe_o)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // one rising edge, inputs then settle 1 ns after it
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_strobes();
        match_i = 1'b0;
        force_i = 1'b0;
        sw_wr_i = 1'b0;
    endtask

    // load the state through the software path (R7 path, no event)
    task automatic load(input logic v);
        idle_strobes();
        sw_wr_i  = 1'b1;
        sw_dat_i = v;
        tick();
        sw_wr_i  = 1'b0;
    endtask

    // read the state through the pin: invert field, output, no strobe
    task automatic peek(input string tag, input logic exp);
        idle_strobes();
        act_mode_i = 2'b01;
        dir_out_i  = 1'b1;
        #1;
        chk(tag, pin_o, exp);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        rst_n = 1'b0;
        tick();
        tick();
        chk("R10 oe in reset", pin_oe_o, 1'b0);
        rst_n = 1'b1;
        peek("R1 state after reset", 1'b0);

        // state path sweep: R2 R3 R4 R5 R6 R7 R8
        for (int s = 0; s < 2; s++) begin
            for (int m = 0; m < 4; m++) begin
                for (int mt = 0; mt < 2; mt++) begin
                    for (int fc = 0; fc < 2; fc++) begin
                        for (int w = 0; w < 2; w++) begin
                            for (int d = 0; d < 2; d++) begin
                                logic exp;
                                logic evt;
                                string tag;
                                load(s[0]);
                                evt = mt[0] | fc[0];
                                if (evt) begin
                                    case (m)
                                        0: exp = s[0];
                                        1: exp = ~s[0];
                                        2: exp = 1'b0;
                                        default: exp = 1'b1;
                                    endcase
                                end else if (w[0]) begin
                                    exp = d[0];
                                end else begin
                                    exp = s[0];
                                end
                                if (evt && w[0])        tag = "R8 event beats write";
                                else if (!evt && w[0])  tag = "R7 sw load";
                                else if (fc[0] && !mt[0]) tag = "R6 force only";
                                else if (!evt)          tag = "R7 idle hold";
                                else if (m == 0)        tag = "R5 hold on event";
                                else if (m == 1)        tag = "R2 invert";
                                else if (m == 2)        tag = "R3 clear";
                                else                    tag = "R4 set";
                                act_mode_i = m[1:0];
                                match_i    = mt[0];
                                force_i    = fc[0];
                                sw_wr_i    = w[0];
                                sw_dat_i   = d[0];
                                tick();
                                peek(tag, exp);
                            end
                        end
                    end
                end
            end
        end

        // pin path sweep: R9 R10
        for (int s = 0; s < 2; s++) begin
            load(s[0]);
            for (int m = 0; m < 4; m++) begin
                for (int dr = 0; dr < 2; dr++) begin
                    for (int p = 0; p < 2; p++) begin
                        logic exp_pin;
                        act_mode_i = m[1:0];
                        dir_out_i  = dr[0];
                        port_dat_i = p[0];
                        #1;
                        if (!dr[0])     exp_pin = 1'b0;
                        else if (m != 0) exp_pin = s[0];
                        else            exp_pin = p[0];
                        chk(dr[0] ? "R9 pin source" : "R10 input pin low", pin_o, exp_pin);
                        chk("R10 oe follows dir", pin_oe_o, dr[0]);
                    end
                end
            end
        end

        // R11: preset while input, then enable
        dir_out_i  = 1'b0;
        act_mode_i = 2'b11;
        port_dat_i = 1'b0;
        load(1'b1);
        tick();
        #1;
        chk("R11 quiet while input", pin_o, 1'b0);
        chk("R11 oe while input", pin_oe_o, 1'b0);
        dir_out_i = 1'b1;
        #1;
        chk("R11 preset on enable", pin_o, 1'b1);
        load(1'b0);
        dir_out_i = 1'b0;
        act_mode_i = 2'b10;
        #1;
        chk("R11 low preset quiet", pin_o, 1'b0);
        dir_out_i = 1'b1;
        #1;
        chk("R11 low preset on enable", pin_o, 1'b0);

        // R1: reset from a set state
        load(1'b1);
        peek("R1 pre-reset state", 1'b1);
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        peek("R1 mid-run reset", 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule